// File: doc/BRIEF.md
# Hardware Cursor Overlay (32 x 32, 2 bits per pixel)

This block draws a small cursor shape on top of a pixel stream. For every incoming pixel it gets the pixel's x/y position and whether the pixel lies in the active area. It also gets the cursor origin, an enable and a mode bit. If the pixel falls inside the 32 x 32 cursor window, a 2-bit code from the cursor bitmap decides what comes out. The code can select one of two programmable colours, pass the input through, or invert the input. The mixed pixel appears one clock later.

The shape is held as 256 bytes with four pixels per byte. It can be written in two ways. A host can write it one byte at a time. It can also be captured in-band from a byte stream. In that case a line flagged as the upload line first carries a configurable number of colour-table bytes, which this block skips. The 256 shape bytes follow straight after them. Video timing, the colour table itself and the colour registers live outside the block. The colours arrive as plain inputs.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pix_out` and `pix_out_valid` are zero, and every bitmap byte reads as 8'hAA, so every cursor pixel holds code 2'b10 (pass-through).
- R2: `pix_out` and `pix_out_valid` are registered. They reflect the pixel inputs presented one clock edge earlier.
- R3: A pixel is covered only when `active` is high and both `0 <= pix_x - cur_x <= 31` and `0 <= pix_y - cur_y <= 31` hold, computed without wrap-around. Any pixel that is not covered leaves unchanged.
- R4: With `cur_en` low, every pixel leaves unchanged, whatever the bitmap holds.
- R5: For the column offset c and row offset r inside the window, the code is read from byte address `r*8 + c/4`, at bits `2*(c%4)+1 : 2*(c%4)`.
- R6: With `cur_mode` = 0, code 0 outputs `cur_col0`, code 1 outputs `cur_col1`, code 2 passes the input, and code 3 outputs the bitwise inverse of the input.
- R7: With `cur_mode` = 1, code 3 passes the input unchanged. Codes 0 to 2 behave as in R6.
- R8: A host write (`host_wr` high) stores `host_data` at byte `host_addr` at the next clock edge.
- R9: After `ib_sol` with `ib_upload` high, the in-band bytes (`ib_valid` high) are counted from 0, starting with any byte in the same cycle as `ib_sol`. Byte indices below LUT_BYTES are skipped. Indices LUT_BYTES to LUT_BYTES+255 are stored at addresses 0 to 255. All later bytes are ignored.
- R10: After `ib_sol` with `ib_upload` low, in-band bytes do not change the bitmap.
- R11: When an in-band store and a host write hit the same clock edge, the in-band byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_in | input | PIX_W | Input pixel |
| pix_x | input | POS_W | Column position of the input pixel |
| pix_y | input | POS_W | Row position of the input pixel |
| active | input | 1 | Pixel lies inside the active area |
| cur_en | input | 1 | Cursor overlay enable |
| cur_x | input | POS_W | Cursor origin column (upper-left) |
| cur_y | input | POS_W | Cursor origin row (upper-left) |
| cur_mode | input | 1 | Code interpretation mode |
| cur_col0 | input | PIX_W | Cursor colour 0 |
| cur_col1 | input | PIX_W | Cursor colour 1 |
| host_wr | input | 1 | Host bitmap byte write strobe |
| host_addr | input | 8 | Host bitmap byte address |
| host_data | input | 8 | Host bitmap byte data |
| ib_sol | input | 1 | Start of an in-band line |
| ib_upload | input | 1 | Line starting now carries the upload |
| ib_valid | input | 1 | In-band byte qualifier |
| ib_byte | input | 8 | In-band byte |
| pix_out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | PIX_W | Mixed output pixel |

## Verification
Random pixel positions are scattered a few pixels around random cursor origins. Enable, active and mode are also random. This separates window-edge errors (off-by-one at offset 31/32, or wrap-around when the pixel is left of or above the origin) from decode errors. Exhaustive 32 x 32 scans with two distinct colours and a random input pixel show every code position. These scans expose any swap of row and column, of byte order or of bit-pair order. They also tell apart all four code actions in both modes. In-band uploads with random gaps check the skip count and the 256-byte window. A same-cycle host write into the upload checks the write priority. A line without the upload flag checks that its bytes are ignored.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

  typedef enum logic [1:0] {
    ACT_COL0 = 2'd0,
    ACT_COL1 = 2'd1,
    ACT_PASS = 2'd2,
    ACT_INV  = 2'd3
  } cur_act_e;

  // Every pixel pair = 2'b10 -> transparent
  localparam logic [7:0] BYTE_ALL_PASS = 8'hAA;

  // Meaning of a 2-bit shape code under the given mode
  function automatic cur_act_e decode_code(input logic mode, input logic [1:0] code);
    cur_act_e a;
    case (code)
      2'd0:    a = ACT_COL0;
      2'd1:    a = ACT_COL1;
      2'd2:    a = ACT_PASS;
      default: a = mode ? ACT_PASS : ACT_INV;
    endcase
    return a;
  endfunction

  // Pixel n of a byte sits in bits 2n+1:2n
  function automatic logic [1:0] pick_slot(input logic [7:0] b, input logic [1:0] slot);
    return b[{slot, 1'b0} +: 2];
  endfunction

endpackage

// File: rtl/cursor_bitmap.sv
module cursor_bitmap #(
  parameter int BYTES = 256,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_data,
  input  logic          ib_wr,
  input  logic [AW-1:0] ib_addr,
  input  logic [7:0]    ib_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);
  import cursor_ovl_pkg::*;

  logic [7:0] mem [BYTES];

  // In-band writer has priority over the host
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  always_comb begin
    wr_en   = ib_wr | host_wr;
    wr_addr = ib_wr ? ib_addr : host_addr;
    wr_data = ib_wr ? ib_data : host_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= BYTE_ALL_PASS;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_byte = mem[rd_addr];

  assert_host_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ib_wr) |=> mem[$past(host_addr)] == $past(host_data));

  assert_inband_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ib_wr |=> mem[$past(ib_addr)] == $past(ib_data));

endmodule

// File: rtl/cursor_loader.sv
module cursor_loader #(
  parameter int LUT_BYTES = 768,
  parameter int BMP_BYTES = 256,
  localparam int END_IDX = LUT_BYTES + BMP_BYTES,
  localparam int CW = $clog2(END_IDX + 1),
  localparam int AW = $clog2(BMP_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ib_sol,
  input  logic          ib_upload,
  input  logic          ib_valid,
  input  logic [7:0]    ib_byte,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);

  localparam logic [CW-1:0] LUT_C  = CW'(LUT_BYTES);
  localparam logic [CW-1:0] LAST_C = CW'(END_IDX - 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;
  logic [CW-1:0] rel;
  logic          live;
  logic          take;

  always_comb begin
    idx  = ib_sol ? '0 : cnt;
    live = ib_sol ? ib_upload : armed;
    take = ib_valid && live;
    rel  = idx - LUT_C;
  end

  assign wr_o   = take && (idx >= LUT_C);
  assign addr_o = rel[AW-1:0];
  assign data_o = ib_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      if (ib_sol) begin
        armed <= ib_upload;
        cnt   <= '0;
      end
      if (take) begin
        cnt <= idx + 1'b1;
        if (idx == LAST_C) armed <= 1'b0;
      end
    end
  end

  // Stores per upload line, for the bound check
  logic [AW:0] stores;
  always_ff @(posedge clk) begin
    if (!rst_n)      stores <= '0;
    else if (ib_sol) stores <= {{AW{1'b0}}, wr_o};
    else if (wr_o)   stores <= stores + 1'b1;
  end

  assert_store_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stores <= (AW+1)'(BMP_BYTES));

  assert_no_write_unarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_sol && !ib_upload) ##1 !ib_sol |-> !wr_o);

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
  parameter int POS_W = 12,
  parameter int CUR   = 32,
  localparam int CB  = $clog2(CUR),
  localparam int AW  = 2 * CB - 2
) (
  input  logic [POS_W-1:0] pix_x,
  input  logic [POS_W-1:0] pix_y,
  input  logic [POS_W-1:0] cur_x,
  input  logic [POS_W-1:0] cur_y,
  input  logic             active,
  input  logic             cur_en,
  output logic             hit,
  output logic [AW-1:0]    byte_addr,
  output logic [1:0]       slot
);

  // Offset inside the window; bit POS_W flags a negative difference
  function automatic logic [POS_W:0] offset(input logic [POS_W-1:0] p, input logic [POS_W-1:0] o);
    return {1'b0, p} - {1'b0, o};
  endfunction

  function automatic logic inside_win(input logic [POS_W:0] d);
    return !d[POS_W] && (d < (POS_W+1)'(CUR));
  endfunction

  logic [POS_W:0] dx, dy;

  always_comb begin
    dx        = offset(pix_x, cur_x);
    dy        = offset(pix_y, cur_y);
    hit       = active && cur_en && inside_win(dx) && inside_win(dy);
    byte_addr = {dy[CB-1:0], dx[CB-1:2]};
    slot      = dx[1:0];
  end

endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [PIX_W-1:0] pix,
  input  logic             hit,
  input  logic [1:0]       code,
  input  logic             mode,
  input  logic [PIX_W-1:0] col0,
  input  logic [PIX_W-1:0] col1,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  import cursor_ovl_pkg::*;

  cur_act_e         act;
  logic [PIX_W-1:0] mixed;

  always_comb begin
    act = hit ? decode_code(mode, code) : ACT_PASS;
    case (act)
      ACT_COL0: mixed = col0;
      ACT_COL1: mixed = col1;
      ACT_INV:  mixed = ~pix;
      default:  mixed = pix;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= valid;
      out_pix   <= mixed;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(valid));

  assert_uncovered_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> out_pix == $past(pix));

  assert_mode1_code3_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode && code == 2'd3) |=> out_pix == $past(pix));

  assert_mode0_code3_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mode && code == 2'd3) |=> out_pix == ~$past(pix));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int PIX_W     = 24,
  parameter int POS_W     = 12,
  parameter int LUT_BYTES = 768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [POS_W-1:0] pix_x,
  input  logic [POS_W-1:0] pix_y,
  input  logic             active,
  input  logic             cur_en,
  input  logic [POS_W-1:0] cur_x,
  input  logic [POS_W-1:0] cur_y,
  input  logic             cur_mode,
  input  logic [PIX_W-1:0] cur_col0,
  input  logic [PIX_W-1:0] cur_col1,
  input  logic             host_wr,
  input  logic [7:0]       host_addr,
  input  logic [7:0]       host_data,
  input  logic             ib_sol,
  input  logic             ib_upload,
  input  logic             ib_valid,
  input  logic [7:0]       ib_byte,
  output logic             pix_out_valid,
  output logic [PIX_W-1:0] pix_out
);
  import cursor_ovl_pkg::*;

  localparam int CUR   = 32;
  localparam int BYTES = CUR * CUR / 4;
  localparam int AW    = $clog2(BYTES);

  logic          ld_wr;
  logic [AW-1:0] ld_addr;
  logic [7:0]    ld_data;
  logic          hit;
  logic [AW-1:0] rd_addr;
  logic [1:0]    slot;
  logic [7:0]    rd_byte;
  logic [1:0]    code;

  cursor_loader #(.LUT_BYTES(LUT_BYTES), .BMP_BYTES(BYTES)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .ib_sol(ib_sol), .ib_upload(ib_upload), .ib_valid(ib_valid), .ib_byte(ib_byte),
    .wr_o(ld_wr), .addr_o(ld_addr), .data_o(ld_data)
  );

  cursor_bitmap #(.BYTES(BYTES)) u_bitmap (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_data(host_data),
    .ib_wr(ld_wr), .ib_addr(ld_addr), .ib_data(ld_data),
    .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  cursor_hit #(.POS_W(POS_W), .CUR(CUR)) u_hit (
    .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
    .active(active), .cur_en(cur_en),
    .hit(hit), .byte_addr(rd_addr), .slot(slot)
  );

  assign code = pick_slot(rd_byte, slot);

  cursor_mixer #(.PIX_W(PIX_W)) u_mixer (
    .clk(clk), .rst_n(rst_n),
    .valid(pix_valid), .pix(pix_in), .hit(hit), .code(code), .mode(cur_mode),
    .col0(cur_col0), .col1(cur_col1),
    .out_valid(pix_out_valid), .out_pix(pix_out)
  );

  assert_disabled_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |=> pix_out == $past(pix_in));

  assert_clipped_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> pix_out == $past(pix_in));

endmodule

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
  localparam int PIX_W = 24;
  localparam int POS_W = 12;
  localparam int LUT   = 768;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             pix_valid;
  logic [PIX_W-1:0] pix_in;
  logic [POS_W-1:0] pix_x, pix_y, cur_x, cur_y;
  logic             active, cur_en, cur_mode;
  logic [PIX_W-1:0] cur_col0, cur_col1;
  logic             host_wr;
  logic [7:0]       host_addr, host_data;
  logic             ib_sol, ib_upload, ib_valid;
  logic [7:0]       ib_byte;
  logic             pix_out_valid;
  logic [PIX_W-1:0] pix_out;

  cursor_overlay #(.PIX_W(PIX_W), .POS_W(POS_W), .LUT_BYTES(LUT)) dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
    .pix_x(pix_x), .pix_y(pix_y), .active(active), .cur_en(cur_en),
    .cur_x(cur_x), .cur_y(cur_y), .cur_mode(cur_mode),
    .cur_col0(cur_col0), .cur_col1(cur_col1),
    .host_wr(host_wr), .host_addr(host_addr), .host_data(host_data),
    .ib_sol(ib_sol), .ib_upload(ib_upload), .ib_valid(ib_valid), .ib_byte(ib_byte),
    .pix_out_valid(pix_out_valid), .pix_out(pix_out)
  );

  int vecs = 0;
  int errs = 0;
  logic [7:0] bm [256];

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Bench restatement of the overlay rules, in signed integer arithmetic
  function automatic logic [PIX_W-1:0] expect_px(input logic [PIX_W-1:0] p,
      input int x, input int y, input int cx, input int cy,
      input bit en, input bit act, input bit mode,
      input logic [PIX_W-1:0] c0, input logic [PIX_W-1:0] c1);
    int dx = x - cx;
    int dy = y - cy;
    int b, c;
    if (!en || !act || dx < 0 || dx > 31 || dy < 0 || dy > 31) return p;
    b = int'(bm[dy * 8 + dx / 4]);
    c = (b >> (2 * (dx % 4))) % 4;
    if (c == 0) return c0;
    if (c == 1) return c1;
    if (c == 2) return p;
    return mode ? p : ~p;
  endfunction

  task automatic apply(input string req, input int x, input int y, input int cx, input int cy,
                       input bit en, input bit act, input bit mode);
    logic [PIX_W-1:0] p = PIX_W'($urandom);
    logic [PIX_W-1:0] e;
    pix_valid = 1'b1; pix_in = p;
    pix_x = POS_W'(x); pix_y = POS_W'(y); cur_x = POS_W'(cx); cur_y = POS_W'(cy);
    cur_en = en; active = act; cur_mode = mode;
    e = expect_px(p, x, y, cx, cy, en, act, mode, cur_col0, cur_col1);
    @(negedge clk);
    check(req, 32'(pix_out), 32'(e));
    check("R2 valid", 32'(pix_out_valid), 32'd1);
    pix_valid = 1'b0;
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = 8'(a); host_data = d;
    @(negedge clk);
    host_wr = 1'b0;
    bm[a] = d;
  endtask

  task automatic scan(input string req, input bit mode);
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < 32; c++)
        apply(req, 300 + c, 40 + r, 300, 40, 1'b1, 1'b1, mode);
  endtask

  // One in-band line; conflict_k >= 0 adds a host write to that address in the same cycle
  task automatic upload(input bit up, input int conflict_k);
    ib_sol = 1'b1; ib_upload = up; ib_valid = 1'b0;
    @(negedge clk);
    ib_sol = 1'b0; ib_upload = 1'b0;
    for (int i = 0; i < LUT + 256 + 6; i++) begin
      if ($urandom % 8 == 0) begin
        ib_valid = 1'b0;
        @(negedge clk);
      end
      ib_valid = 1'b1;
      ib_byte  = 8'($urandom);
      if (conflict_k >= 0 && i == LUT + conflict_k) begin
        host_wr = 1'b1; host_addr = 8'(conflict_k); host_data = ~ib_byte;
      end
      if (up && i >= LUT && i < LUT + 256) bm[i - LUT] = ib_byte;
      @(negedge clk);
      host_wr = 1'b0;
    end
    ib_valid = 1'b0;
  endtask

  initial begin
    #(20ns * 190000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; pix_valid = 1'b0; pix_in = '0; pix_x = '0; pix_y = '0;
    cur_x = '0; cur_y = '0; active = 1'b0; cur_en = 1'b0; cur_mode = 1'b0;
    cur_col0 = 24'h12_34_56; cur_col1 = 24'hC0_FF_EE;
    host_wr = 1'b0; host_addr = '0; host_data = '0;
    ib_sol = 1'b0; ib_upload = 1'b0; ib_valid = 1'b0; ib_byte = '0;
    for (int i = 0; i < 256; i++) bm[i] = 8'hAA;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out", 32'(pix_out), 32'd0);
    check("R1 valid", 32'(pix_out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    scan("R1 cleared bitmap", 1'b0);

    // R8 / R5 / R6: host-loaded shape, exhaustive scan in both modes (R7)
    for (int a = 0; a < 256; a++) host_write(a, 8'($urandom));
    host_write(0, 8'b11_10_01_00);   // directed: slots 0..3 carry codes 0..3
    host_write(255, 8'hE4);
    scan("R5 R6 mode0 scan", 1'b0);
    scan("R7 mode1 scan", 1'b1);

    // R3 window edges and wrap-around, R4 enable
    apply("R3 left of origin", 299, 40, 300, 40, 1'b1, 1'b1, 1'b0);
    apply("R3 col 32", 332, 40, 300, 40, 1'b1, 1'b1, 1'b0);
    apply("R3 row 32", 300, 72, 300, 40, 1'b1, 1'b1, 1'b0);
    apply("R3 clipped", 300, 40, 300, 40, 1'b1, 1'b0, 1'b0);
    apply("R4 disabled", 300, 40, 300, 40, 1'b0, 1'b1, 1'b0);
    apply("R3 origin near max", 4095, 4095, 4090, 4090, 1'b1, 1'b1, 1'b0);
    apply("R3 no wrap", 5, 5, 4090, 4090, 1'b1, 1'b1, 1'b0);

    // Random mix around random origins
    for (int n = 0; n < 3000; n++) begin
      int cx = int'($urandom_range(8, 4000));
      int cy = int'($urandom_range(8, 4000));
      apply("R3 R4 R6 R7 random",
            cx + int'($urandom_range(0, 40)) - 4, cy + int'($urandom_range(0, 40)) - 4,
            cx, cy, ($urandom % 8) != 0, ($urandom % 8) != 0, 1'($urandom));
    end

    // R9 in-band upload with R11 conflict at address 5
    upload(1'b1, 5);
    scan("R9 R11 in-band scan", 1'b0);
    // R10 line without upload flag is ignored
    upload(1'b0, -1);
    scan("R10 ignored line scan", 1'b0);
    // R9 again, no conflict, mode 1
    upload(1'b1, -1);
    scan("R9 second upload scan", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule